// File: doc/BRIEF.md
# Working Register File with Data-Space Window

This block holds the thirty-two 8-bit working registers of a small CPU core. The ALU reads two operands through two independent combinational read ports and writes one result per clock. The top six registers pair up into three 16-bit indirect pointers. A dedicated 16-bit write-back port lets the address unit store an incremented or decremented pointer in a single edge.

The same storage also appears at the bottom of the 16-bit data space. A load or store whose address falls in the first 32 bytes reaches the registers directly. Addresses in the standard I/O, extended I/O and on-chip SRAM windows are only flagged on region-select outputs. The units that own those windows serve them.

Top module: `rf_dspace`

## Requirements
- R1: A synchronous active-high reset clears all 32 registers to 0x00, and no write lands while reset is high.
- R2: Read ports A and B return the present contents of the registers named by `rd_a_idx` and `rd_b_idx` combinationally, with independent indices.
- R3: With `alu_we` high at a rising edge, register `alu_widx` takes `alu_wdata` and shows it from the next cycle on. A read of that register in the write cycle returns the old value.
- R4: Data addresses 0x0000 to 0x001F map onto registers 0 to 31. `ds_rdata` shows that register combinationally, and `ds_we` writes `ds_wdata` into it at the edge. For any other address `ds_rdata` is 0x00 and `ds_we` changes no register.
- R5: `sel_reg` is high for 0x0000 to 0x001F, `sel_io` for 0x0020 to 0x005F, `sel_ext` for 0x0060 to 0x00FF and `sel_sram` for 0x0100 to 0x08FF. No select is high above 0x08FF, and at most one is ever high.
- R6: `ptr_x` is {r27,r26}, `ptr_y` is {r29,r28} and `ptr_z` is {r31,r30}, with the even register as the low byte. All three are visible at all times.
- R7: With `ptr_we` high, `ptr_sel` chooses a pair: 0 is X, 1 is Y, 2 is Z. Both bytes of that pair take `ptr_wdata` at one edge. `ptr_sel`=3 writes nothing.
- R8: When several write sources hit the same register at one edge, the ALU port wins over the pointer port, and the pointer port wins over the data-space port. Writes to different registers at the same edge all land.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 8 | Read port A data |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 8 | Read port B data |
| alu_we | input | 1 | ALU result write enable |
| alu_widx | input | 5 | ALU result register index |
| alu_wdata | input | 8 | ALU result data |
| ptr_we | input | 1 | Pointer write-back enable |
| ptr_sel | input | 2 | Pointer pair select (0 X, 1 Y, 2 Z, 3 none) |
| ptr_wdata | input | 16 | Pointer write-back value |
| ptr_x | output | 16 | Pointer X {r27,r26} |
| ptr_y | output | 16 | Pointer Y {r29,r28} |
| ptr_z | output | 16 | Pointer Z {r31,r30} |
| ds_addr | input | 16 | Data-space address |
| ds_we | input | 1 | Data-space store strobe |
| ds_wdata | input | 8 | Data-space store data |
| ds_rdata | output | 8 | Data-space load data from the register window |
| sel_reg | output | 1 | Address in register window |
| sel_io | output | 1 | Address in standard I/O window |
| sel_ext | output | 1 | Address in extended I/O window |
| sel_sram | output | 1 | Address in internal SRAM window |

## Verification
The bench probes each window edge on both sides: 0x001F/0x0020, 0x005F/0x0060, 0x00FF/0x0100 and 0x08FF/0x0900. An off-by-one compare would raise two selects or none there. It stores to 0x0040 and 0x0025, whose low five bits alias registers 0 and 5. A decoder that used only the low address bits would corrupt those registers. Same-edge collisions of the ALU, pointer and data-space ports on one register would expose a wrong priority as the losing value in the register. A read during a write that bypassed the new data would show up as the new value one cycle early. A pointer select of 3 that leaked through, or swapped byte halves in the pointer port, would show as changed or reversed bytes on the pointer outputs.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_DW    = 8;
  localparam int unsigned RF_NREG  = 32;
  localparam int unsigned RF_DSAW  = 16;
  localparam int unsigned RF_IO_LO   = 32'h0020;
  localparam int unsigned RF_EXT_LO  = 32'h0060;
  localparam int unsigned RF_SRAM_LO = 32'h0100;
  localparam int unsigned RF_SRAM_END = 32'h0900;

  typedef enum logic [1:0] {
    PTR_X    = 2'd0,
    PTR_Y    = 2'd1,
    PTR_Z    = 2'd2,
    PTR_NONE = 2'd3
  } ptr_sel_e;
endpackage

// File: rtl/rf_ds_decode.sv
module rf_ds_decode #(
  parameter int unsigned DSAW     = rf_pkg::RF_DSAW,
  parameter int unsigned IO_LO    = rf_pkg::RF_IO_LO,
  parameter int unsigned EXT_LO   = rf_pkg::RF_EXT_LO,
  parameter int unsigned SRAM_LO  = rf_pkg::RF_SRAM_LO,
  parameter int unsigned SRAM_END = rf_pkg::RF_SRAM_END
) (
  input  logic [DSAW-1:0] addr,
  output logic            hit_reg,
  output logic            hit_io,
  output logic            hit_ext,
  output logic            hit_sram
);
  localparam logic [DSAW-1:0] B_IO   = DSAW'(IO_LO);
  localparam logic [DSAW-1:0] B_EXT  = DSAW'(EXT_LO);
  localparam logic [DSAW-1:0] B_SRAM = DSAW'(SRAM_LO);
  localparam logic [DSAW-1:0] B_TOP  = DSAW'(SRAM_END);

  assign hit_reg  = (addr < B_IO);
  assign hit_io   = (addr >= B_IO)   && (addr < B_EXT);
  assign hit_ext  = (addr >= B_EXT)  && (addr < B_SRAM);
  assign hit_sram = (addr >= B_SRAM) && (addr < B_TOP);
endmodule

// File: rtl/rf_wsel.sv
module rf_wsel #(
  parameter int unsigned DW       = 8,
  parameter int unsigned AW       = 5,
  parameter int unsigned IDX      = 0,
  parameter int unsigned PTR_BASE = 26
) (
  input  logic            alu_we,
  input  logic [AW-1:0]   alu_idx,
  input  logic [DW-1:0]   alu_wd,
  input  logic            ptr_we,
  input  logic [1:0]      ptr_sel,
  input  logic [2*DW-1:0] ptr_wd,
  input  logic            mem_we,
  input  logic [AW-1:0]   mem_idx,
  input  logic [DW-1:0]   mem_wd,
  output logic            we,
  output logic [DW-1:0]   wd
);
  localparam logic [AW-1:0] MY     = AW'(IDX);
  localparam bit            IS_PTR = (IDX >= PTR_BASE);
  localparam int unsigned   OFS    = IS_PTR ? (IDX - PTR_BASE) : 0;
  localparam logic [1:0]    PAIR   = 2'(OFS / 2);
  localparam bit            HI     = ((OFS % 2) == 1);

  logic          alu_hit, ptr_hit, mem_hit;
  logic [DW-1:0] ptr_byte;

  assign alu_hit  = alu_we && (alu_idx == MY);
  assign ptr_hit  = IS_PTR && ptr_we && (ptr_sel == PAIR) &&
                    (ptr_sel != rf_pkg::PTR_NONE);
  assign mem_hit  = mem_we && (mem_idx == MY);
  assign ptr_byte = HI ? ptr_wd[2*DW-1:DW] : ptr_wd[DW-1:0];

  // ALU result first, then pointer write-back, then data-space store
  always_comb begin
    we = alu_hit || ptr_hit || mem_hit;
    if (alu_hit)      wd = alu_wd;
    else if (ptr_hit) wd = ptr_byte;
    else              wd = mem_wd;
  end
endmodule

// File: rtl/rf_store.sv
module rf_store #(
  parameter int unsigned DW       = 8,
  parameter int unsigned NREG     = 32,
  parameter int unsigned AW       = 5,
  parameter int unsigned PTR_BASE = 26
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alu_we,
  input  logic [AW-1:0]      alu_idx,
  input  logic [DW-1:0]      alu_wd,
  input  logic               ptr_we,
  input  logic [1:0]         ptr_sel,
  input  logic [2*DW-1:0]    ptr_wd,
  input  logic               mem_we,
  input  logic [AW-1:0]      mem_idx,
  input  logic [DW-1:0]      mem_wd,
  output logic [NREG*DW-1:0] q_flat
);
  logic [DW-1:0] q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic          we_g;
    logic [DW-1:0] wd_g;

    rf_wsel #(.DW(DW), .AW(AW), .IDX(g), .PTR_BASE(PTR_BASE)) u_wsel (
      .alu_we (alu_we),  .alu_idx(alu_idx), .alu_wd(alu_wd),
      .ptr_we (ptr_we),  .ptr_sel(ptr_sel), .ptr_wd(ptr_wd),
      .mem_we (mem_we),  .mem_idx(mem_idx), .mem_wd(mem_wd),
      .we     (we_g),    .wd     (wd_g)
    );

    always_ff @(posedge clk) begin
      if (rst)       q[g] <= '0;
      else if (we_g) q[g] <= wd_g;
    end

    assign q_flat[g*DW +: DW] = q[g];
  end
endmodule

// File: rtl/rf_dspace.sv
module rf_dspace #(
  parameter int unsigned DW       = rf_pkg::RF_DW,
  parameter int unsigned NREG     = rf_pkg::RF_NREG,
  parameter int unsigned DSAW     = rf_pkg::RF_DSAW,
  parameter int unsigned IO_LO    = rf_pkg::RF_IO_LO,
  parameter int unsigned EXT_LO   = rf_pkg::RF_EXT_LO,
  parameter int unsigned SRAM_LO  = rf_pkg::RF_SRAM_LO,
  parameter int unsigned SRAM_END = rf_pkg::RF_SRAM_END,
  localparam int unsigned AW      = $clog2(NREG),
  localparam int unsigned PW      = 2 * DW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   rd_a_idx,
  output logic [DW-1:0]   rd_a_data,
  input  logic [AW-1:0]   rd_b_idx,
  output logic [DW-1:0]   rd_b_data,
  input  logic            alu_we,
  input  logic [AW-1:0]   alu_widx,
  input  logic [DW-1:0]   alu_wdata,
  input  logic            ptr_we,
  input  logic [1:0]      ptr_sel,
  input  logic [PW-1:0]   ptr_wdata,
  output logic [PW-1:0]   ptr_x,
  output logic [PW-1:0]   ptr_y,
  output logic [PW-1:0]   ptr_z,
  input  logic [DSAW-1:0] ds_addr,
  input  logic            ds_we,
  input  logic [DW-1:0]   ds_wdata,
  output logic [DW-1:0]   ds_rdata,
  output logic            sel_reg,
  output logic            sel_io,
  output logic            sel_ext,
  output logic            sel_sram
);
  localparam int unsigned PTR_BASE = NREG - 6;

  logic [NREG*DW-1:0] q_flat;
  logic               mem_we;
  logic [AW-1:0]      mem_idx;

  rf_ds_decode #(
    .DSAW(DSAW), .IO_LO(IO_LO), .EXT_LO(EXT_LO),
    .SRAM_LO(SRAM_LO), .SRAM_END(SRAM_END)
  ) u_dec (
    .addr(ds_addr), .hit_reg(sel_reg), .hit_io(sel_io),
    .hit_ext(sel_ext), .hit_sram(sel_sram)
  );

  assign mem_we  = ds_we && sel_reg;
  assign mem_idx = ds_addr[AW-1:0];

  rf_store #(.DW(DW), .NREG(NREG), .AW(AW), .PTR_BASE(PTR_BASE)) u_store (
    .clk(clk), .rst(rst),
    .alu_we(alu_we), .alu_idx(alu_widx), .alu_wd(alu_wdata),
    .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_wd(ptr_wdata),
    .mem_we(mem_we), .mem_idx(mem_idx), .mem_wd(ds_wdata),
    .q_flat(q_flat)
  );

  assign rd_a_data = q_flat[rd_a_idx*DW +: DW];
  assign rd_b_data = q_flat[rd_b_idx*DW +: DW];
  assign ds_rdata  = sel_reg ? q_flat[mem_idx*DW +: DW] : '0;

  assign ptr_x = q_flat[PTR_BASE*DW       +: PW];
  assign ptr_y = q_flat[(PTR_BASE+2)*DW   +: PW];
  assign ptr_z = q_flat[(PTR_BASE+4)*DW   +: PW];
endmodule

// File: rtl/rf_dspace_chk.sv
module rf_dspace_chk #(
  parameter int unsigned DW   = 8,
  parameter int unsigned AW   = 5,
  parameter int unsigned DSAW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [AW-1:0]   rd_a_idx,
  input logic [DW-1:0]   rd_a_data,
  input logic            alu_we,
  input logic [AW-1:0]   alu_widx,
  input logic [DW-1:0]   alu_wdata,
  input logic            ptr_we,
  input logic [1:0]      ptr_sel,
  input logic [2*DW-1:0] ptr_wdata,
  input logic [2*DW-1:0] ptr_x,
  input logic [2*DW-1:0] ptr_z,
  input logic [DSAW-1:0] ds_addr,
  input logic            ds_we,
  input logic [DW-1:0]   ds_wdata,
  input logic [DW-1:0]   ds_rdata,
  input logic            sel_reg,
  input logic            sel_io,
  input logic            sel_ext,
  input logic            sel_sram
);
  localparam logic [DSAW-1:0] TOP_ADDR = DSAW'(32'h08FF);

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_a_data == '0)); // R1

  AST_ALU_LANDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(alu_we) && (rd_a_idx == $past(alu_widx)))
      |-> (rd_a_data == $past(alu_wdata))); // R3

  AST_MEM_LANDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ds_we && sel_reg && !alu_we && !ptr_we) &&
     (ds_addr == $past(ds_addr))) |-> (ds_rdata == $past(ds_wdata))); // R4

  AST_DS_RD_ZERO: assert property (@(posedge clk) disable iff (rst)
    !sel_reg |-> (ds_rdata == '0)); // R4

  AST_REGION_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_reg, sel_io, sel_ext, sel_sram})); // R5

  AST_REGION_ABOVE: assert property (@(posedge clk) disable iff (rst)
    (ds_addr > TOP_ADDR) |-> ({sel_reg, sel_io, sel_ext, sel_sram} == 4'b0000)); // R5

  AST_PTR_X_LANDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ptr_we) && ($past(ptr_sel) == 2'd0) && !$past(alu_we))
      |-> (ptr_x == $past(ptr_wdata))); // R7

  AST_PTR_NONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ptr_we) && ($past(ptr_sel) == 2'd3) &&
     !$past(alu_we) && !$past(ds_we)) |-> (ptr_z == $past(ptr_z))); // R7

  AST_ALU_OVER_MEM: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(alu_we && ds_we && sel_reg && (ds_addr[AW-1:0] == alu_widx)) &&
     (ds_addr == $past(ds_addr))) |-> (ds_rdata == $past(alu_wdata))); // R8
endmodule

bind rf_dspace rf_dspace_chk #(.DW(DW), .AW(AW), .DSAW(DSAW)) u_chk (
  .clk(clk), .rst(rst), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .alu_we(alu_we), .alu_widx(alu_widx), .alu_wdata(alu_wdata),
  .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_wdata(ptr_wdata),
  .ptr_x(ptr_x), .ptr_z(ptr_z), .ds_addr(ds_addr), .ds_we(ds_we),
  .ds_wdata(ds_wdata), .ds_rdata(ds_rdata), .sel_reg(sel_reg),
  .sel_io(sel_io), .sel_ext(sel_ext), .sel_sram(sel_sram)
);

// File: tb/sim_rf_dspace.sv
`timescale 1ns/1ps
module sim_rf_dspace;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  rd_a_idx, rd_b_idx, alu_widx;
  logic [7:0]  rd_a_data, rd_b_data, alu_wdata, ds_wdata, ds_rdata;
  logic        alu_we, ptr_we, ds_we;
  logic [1:0]  ptr_sel;
  logic [15:0] ptr_wdata, ptr_x, ptr_y, ptr_z, ds_addr;
  logic        sel_reg, sel_io, sel_ext, sel_sram;

  always #2.5 clk = ~clk;

  rf_dspace u0 (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .alu_we(alu_we), .alu_widx(alu_widx), .alu_wdata(alu_wdata),
    .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_wdata(ptr_wdata),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
    .ds_addr(ds_addr), .ds_we(ds_we), .ds_wdata(ds_wdata), .ds_rdata(ds_rdata),
    .sel_reg(sel_reg), .sel_io(sel_io), .sel_ext(sel_ext), .sel_sram(sel_sram)
  );

  typedef struct {
    int          kind;   // 0 rdA 1 rdB 2 ds_rdata 3 X 4 Y 5 Z 6 selects
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t       sb[$];
  logic [7:0]  m [32];
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;

  function automatic logic [15:0] observe(int kind);
    case (kind)
      0: return {8'h00, rd_a_data};
      1: return {8'h00, rd_b_data};
      2: return {8'h00, ds_rdata};
      3: return ptr_x;
      4: return ptr_y;
      5: return ptr_z;
      default: return {12'h000, sel_reg, sel_io, sel_ext, sel_sram};
    endcase
  endfunction

  // monitor: compares queued expectations after inputs settle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [15:0] got;
        it  = sb.pop_front();
        got = observe(it.kind);
        checks++;
        if (got !== it.exp) begin
          fails++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, got, it.exp);
        end
      end
    end
  end

  task automatic push(int kind, logic [15:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle();
    alu_we = 0; alu_widx = 0; alu_wdata = 0;
    ptr_we = 0; ptr_sel = 0; ptr_wdata = 0;
    ds_we = 0; ds_addr = 16'hFFFF; ds_wdata = 0;
  endtask

  // one write edge; port A observes the ALU target in the write cycle
  task automatic wr(bit awe, logic [4:0] ai, logic [7:0] ad,
                    bit pwe, logic [1:0] ps, logic [15:0] pd,
                    bit dwe, logic [15:0] da, logic [7:0] dd);
    alu_we = awe; alu_widx = ai; alu_wdata = ad;
    ptr_we = pwe; ptr_sel = ps; ptr_wdata = pd;
    ds_we = dwe; ds_addr = da; ds_wdata = dd;
    rd_a_idx = ai;
    push(0, {8'h00, m[ai]}, "R3 read-during-write old value");
    @(negedge clk);
    if (dwe && da < 16'h0020) m[da[4:0]] = dd;
    if (pwe && ps != 2'd3) begin
      m[26 + 2*ps] = pd[7:0];
      m[27 + 2*ps] = pd[15:8];
    end
    if (awe) m[ai] = ad;
    idle();
  endtask

  task automatic chk_reg(int i, string tag);
    rd_a_idx = 5'(i); rd_b_idx = 5'(31 - i); ds_addr = 16'(i);
    push(0, {8'h00, m[i]}, tag);
    push(1, {8'h00, m[31 - i]}, tag);
    push(2, {8'h00, m[i]}, tag);
    @(negedge clk);
    ds_addr = 16'hFFFF;
  endtask

  task automatic chk_ptr(string tag);
    push(3, {m[27], m[26]}, tag);
    push(4, {m[29], m[28]}, tag);
    push(5, {m[31], m[30]}, tag);
    @(negedge clk);
  endtask

  task automatic chk_region(logic [15:0] a, logic [3:0] s);
    ds_addr = a;
    push(6, {12'h000, s}, "R5 region select");
    push(2, s[3] ? {8'h00, m[a[4:0]]} : 16'h0000, "R4 window read / zero outside");
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) m[i] = 8'h00;
    rd_a_idx = 0; rd_b_idx = 0;
    idle();
    rst = 1'b1;
    // writes presented during reset must not land (R1)
    alu_we = 1; alu_widx = 5'd3; alu_wdata = 8'hFF;
    ds_we = 1; ds_addr = 16'h0004; ds_wdata = 8'hEE;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();

    for (int i = 0; i < 32; i++) chk_reg(i, "R1 reset clears");
    chk_ptr("R1 pointers zero after reset");

    // R3 ALU writes every register, reading old value in the write cycle
    for (int i = 0; i < 32; i++) wr(1, 5'(i), 8'(i * 7 + 3), 0, 0, 0, 0, 16'hFFFF, 0);
    // R2 both read ports and R4 window readback
    for (int i = 0; i < 32; i++) chk_reg(i, "R2 dual read / R4 window read");
    chk_ptr("R6 pointer pairing");

    // R4 data-space stores: in window, and aliasing addresses outside
    wr(0, 5'd5, 0, 0, 0, 0, 1, 16'h0005, 8'hA5);
    chk_reg(5, "R4 store lands");
    wr(0, 5'd0, 0, 0, 0, 0, 1, 16'h0040, 8'hFF);
    wr(0, 5'd5, 0, 0, 0, 0, 1, 16'h0025, 8'h11);
    wr(0, 5'd0, 0, 0, 0, 0, 1, 16'h0900, 8'h22);
    chk_reg(0, "R4 out-of-window store ignored");
    chk_reg(5, "R4 out-of-window store ignored");
    chk_reg(31, "R4 out-of-window store ignored");

    // R5 window boundaries
    chk_region(16'h0000, 4'b1000);
    chk_region(16'h001F, 4'b1000);
    chk_region(16'h0020, 4'b0100);
    chk_region(16'h005F, 4'b0100);
    chk_region(16'h0060, 4'b0010);
    chk_region(16'h00FF, 4'b0010);
    chk_region(16'h0100, 4'b0001);
    chk_region(16'h08FF, 4'b0001);
    chk_region(16'h0900, 4'b0000);
    chk_region(16'hFFFF, 4'b0000);

    // R7 pointer write-back
    wr(0, 5'd0, 0, 1, 2'd0, 16'h1234, 0, 16'hFFFF, 0);
    chk_ptr("R7 write X");
    wr(0, 5'd0, 0, 1, 2'd1, 16'hBEEF, 0, 16'hFFFF, 0);
    chk_ptr("R7 write Y");
    wr(0, 5'd0, 0, 1, 2'd2, 16'hFFFF, 0, 16'hFFFF, 0);
    chk_ptr("R7 write Z");
    wr(0, 5'd0, 0, 1, 2'd2, 16'h0000, 0, 16'hFFFF, 0);
    chk_ptr("R7 Z wraps on increment");
    wr(0, 5'd0, 0, 1, 2'd3, 16'h5555, 0, 16'hFFFF, 0);
    chk_ptr("R7 select 3 writes nothing");
    chk_reg(26, "R6 low byte of X on port A");

    // R8 write priority
    wr(1, 5'd26, 8'h11, 1, 2'd0, 16'h2222, 1, 16'h001A, 8'h33);
    chk_ptr("R8 ALU over pointer over store");
    wr(0, 5'd0, 0, 1, 2'd1, 16'h4444, 1, 16'h001C, 8'h55);
    chk_ptr("R8 pointer over store");
    wr(1, 5'd4, 8'h77, 1, 2'd2, 16'h8899, 1, 16'h0003, 8'h66);
    chk_reg(3, "R8 distinct targets all land");
    chk_reg(4, "R8 distinct targets all land");
    chk_ptr("R8 distinct targets all land");
    wr(1, 5'd9, 8'hC3, 0, 0, 0, 1, 16'h0009, 8'h3C);
    chk_reg(9, "R8 ALU over store");

    @(negedge clk);
    #2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule